// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the byte address stream for a single DMA channel. A start pulse captures a base address, an inner (row) element count with its signed byte step, and an outer (column) count with its own signed byte step. While the channel is busy, every cycle in which the consumer raises an element request is one accepted element. One cycle later the block presents the address of that element.

Inside a row the address advances by the inner step. When a row ends, it advances by the outer step instead and the inner count starts again. The outer step is independent of the inner step and can be smaller than it or negative, so interleaved streams can be pulled apart as they are read. A transfer with the two-dimensional flag clear is a single row.

At the end of the buffer the channel does one of two things. In stop mode it goes idle. In circular mode it returns to the base address and runs the buffer again. Interrupt pulses mark the end of each row and the end of each buffer pass. Descriptor fetching, arbitration and the data path are not part of this block.

Top module: `dma2d_addr_gen`

## Requirements
- R1: In reset and after it, `busy`, `addr_vld`, `row_done` and `buf_done` are low.
- R2: The cycle after `start` is sampled high, `busy` is high and the configuration is captured. This also applies when `start` arrives while the channel is already busy, and then the transfer restarts. An element request sampled while `busy` is high and `start` is low is accepted. The next cycle, `addr_vld` is high with `addr` equal to the element's address. The first element's address is the base address.
- R3: Within a row, each accepted element moves the current address by the inner step. The inner step is a 16-bit two's-complement byte value, sign-extended to 32 bits.
- R4: After the last element of a row that is not the last row, the address moves by the sign-extended 16-bit outer step instead, and the inner count reloads. The outer step may be smaller than the inner step or negative.
- R5: A count field of 0 means 65536 elements. Any other value N means N elements.
- R6: When `cfg_two_d` is 0, the outer count is ignored and the buffer is one row of inner-count elements.
- R7: With `cfg_circular` = 0, `busy` is low from the clock edge that accepts the final element of the buffer. Requests made while idle produce no `addr_vld`.
- R8: With `cfg_circular` = 1, the element after the final one takes the base address again. `busy` stays high and the same sequence repeats.
- R9: `buf_done` is high for exactly the cycle in which `addr_vld` presents the final element of a buffer pass.
- R10: `row_done` is high for the cycle in which `addr_vld` presents the last element of any row, including the last row. This happens only when both `cfg_two_d` and `cfg_row_irq_en` are 1. Otherwise `row_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture configuration and begin a transfer |
| cfg_start_addr | input | 32 | Base byte address |
| cfg_x_count | input | 16 | Elements per row (0 = 65536) |
| cfg_x_step | input | 16 | Signed byte step inside a row |
| cfg_y_count | input | 16 | Rows per buffer (0 = 65536) |
| cfg_y_step | input | 16 | Signed byte step applied after a row |
| cfg_two_d | input | 1 | 1 = two-dimensional, 0 = single row |
| cfg_circular | input | 1 | 1 = restart at end, 0 = stop at end |
| cfg_row_irq_en | input | 1 | Enable per-row completion pulse |
| elem_req | input | 1 | Element request from the consumer |
| busy | output | 1 | Channel running |
| addr_vld | output | 1 | `addr` holds an issued element address |
| addr | output | 32 | Issued byte address |
| row_done | output | 1 | Row completion pulse |
| buf_done | output | 1 | Buffer completion pulse |

## Verification
Row completion and buffer completion fall in the same cycle on the last element of the last row of a two-dimensional transfer with row pulses enabled. In circular mode, that same cycle also carries the address wrap. The bench provokes this with directed circular and stop-mode transfers and with random configurations whose short counts reach the final element often. A reference model in the bench predicts, for every cycle, whether each pulse is present, what the address is and what `busy` does afterwards, and all of these are compared on the same cycle.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;

  typedef struct packed {
    logic vld;
    logic row;
    logic buf_end;
  } issue_flags_t;
endpackage

// File: rtl/dma2d_dim_counter.sv
module dma2d_dim_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          force_one,
  input  logic          step,
  output logic          last
);
  localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};
  localparam logic [CW:0] ONE  = {{CW{1'b0}}, 1'b1};

  logic [CW:0] cnt_q;
  logic [CW:0] rld_q;
  logic [CW:0] init_val;

  always_comb begin
    if (force_one)
      init_val = ONE;
    else if (load_val == '0)
      init_val = FULL;
    else
      init_val = {1'b0, load_val};
  end

  assign last = (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ONE;
      rld_q <= ONE;
    end else if (load) begin
      cnt_q <= init_val;
      rld_q <= init_val;
    end else if (step) begin
      cnt_q <= last ? rld_q : cnt_q - ONE;
    end
  end
endmodule

// File: rtl/dma2d_addr_unit.sv
module dma2d_addr_unit #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] inner_step,
  input  logic [SW-1:0] outer_step,
  input  logic          accept,
  input  logic          row_end,
  input  logic          buf_end,
  output logic [AW-1:0] addr
);
  localparam int EXT = AW - SW;

  logic [AW-1:0] base_q;
  logic [AW-1:0] cur_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] in_q;
  logic [SW-1:0] out_q;
  logic [SW-1:0] sel_step;
  logic [AW-1:0] step_ext;

  assign sel_step = row_end ? out_q : in_q;
  assign step_ext = {{EXT{sel_step[SW-1]}}, sel_step};
  assign addr     = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cur_q  <= '0;
      addr_q <= '0;
      in_q   <= '0;
      out_q  <= '0;
    end else if (load) begin
      base_q <= base;
      cur_q  <= base;
      in_q   <= inner_step;
      out_q  <= outer_step;
    end else if (accept) begin
      addr_q <= cur_q;
      cur_q  <= buf_end ? base_q : cur_q + step_ext;
    end
  end
endmodule

// File: rtl/dma2d_seq_ctrl.sv
module dma2d_seq_ctrl
  import dma2d_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic circular,
  input  logic row_irq,
  input  logic elem_req,
  input  logic x_last,
  input  logic y_last,
  output logic accept,
  output logic busy,
  output logic circ_q,
  output logic addr_vld,
  output logic row_done,
  output logic buf_done
);
  run_state_e   state_q;
  logic         row_irq_q;
  issue_flags_t flags_q;

  assign busy     = (state_q == RUN_ACTIVE);
  assign accept   = busy && elem_req && !start;
  assign addr_vld = flags_q.vld;
  assign row_done = flags_q.row;
  assign buf_done = flags_q.buf_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RUN_IDLE;
      circ_q    <= 1'b0;
      row_irq_q <= 1'b0;
      flags_q   <= '0;
    end else begin
      flags_q.vld     <= accept;
      flags_q.row     <= accept && x_last && row_irq_q;
      flags_q.buf_end <= accept && x_last && y_last;
      if (start) begin
        state_q   <= RUN_ACTIVE;
        circ_q    <= circular;
        row_irq_q <= row_irq;
      end else if (accept && x_last && y_last && !circ_q) begin
        state_q <= RUN_IDLE;
      end
    end
  end
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] cfg_start_addr,
  input  logic [CW-1:0] cfg_x_count,
  input  logic [SW-1:0] cfg_x_step,
  input  logic [CW-1:0] cfg_y_count,
  input  logic [SW-1:0] cfg_y_step,
  input  logic          cfg_two_d,
  input  logic          cfg_circular,
  input  logic          cfg_row_irq_en,
  input  logic          elem_req,
  output logic          busy,
  output logic          addr_vld,
  output logic [AW-1:0] addr,
  output logic          row_done,
  output logic          buf_done
);
  logic accept;
  logic x_last;
  logic y_last;
  logic circ_q;

  dma2d_dim_counter #(.CW(CW)) u_xcnt (
    .clk(clk), .rst(rst), .load(start), .load_val(cfg_x_count),
    .force_one(1'b0), .step(accept), .last(x_last)
  );

  dma2d_dim_counter #(.CW(CW)) u_ycnt (
    .clk(clk), .rst(rst), .load(start), .load_val(cfg_y_count),
    .force_one(!cfg_two_d), .step(accept && x_last), .last(y_last)
  );

  dma2d_addr_unit #(.AW(AW), .SW(SW)) u_addr (
    .clk(clk), .rst(rst), .load(start), .base(cfg_start_addr),
    .inner_step(cfg_x_step), .outer_step(cfg_y_step), .accept(accept),
    .row_end(x_last), .buf_end(x_last && y_last), .addr(addr)
  );

  dma2d_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .circular(cfg_circular),
    .row_irq(cfg_two_d && cfg_row_irq_en), .elem_req(elem_req),
    .x_last(x_last), .y_last(y_last), .accept(accept), .busy(busy),
    .circ_q(circ_q), .addr_vld(addr_vld), .row_done(row_done),
    .buf_done(buf_done)
  );
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic elem_req,
  input logic busy,
  input logic circ_q,
  input logic addr_vld,
  input logic row_done,
  input logic buf_done
);
  assert_vld_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    addr_vld |-> $past(busy && elem_req && !start));

  assert_idle_no_issue_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !addr_vld);

  assert_stop_goes_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (buf_done && !circ_q) |-> !busy);

  assert_circ_stays_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (buf_done && circ_q) |-> busy);

  assert_buf_with_addr_R9: assert property (@(posedge clk) disable iff (rst)
    buf_done |-> addr_vld);

  assert_row_with_addr_R10: assert property (@(posedge clk) disable iff (rst)
    row_done |-> addr_vld);
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .elem_req(elem_req), .busy(busy),
  .circ_q(circ_q), .addr_vld(addr_vld), .row_done(row_done), .buf_done(buf_done)
);

// File: tb/dma2d_addr_gen_tb.sv
`timescale 1ns/1ps
module dma2d_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cfg_start_addr = '0;
  logic [15:0] cfg_x_count = '0, cfg_x_step = '0, cfg_y_count = '0, cfg_y_step = '0;
  logic        cfg_two_d = 1'b0, cfg_circular = 1'b0, cfg_row_irq_en = 1'b0;
  logic        elem_req = 1'b0;
  logic        busy, addr_vld, row_done, buf_done;
  logic [31:0] addr;

  always #2.5 clk = ~clk;

  dma2d_addr_gen u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_start_addr(cfg_start_addr),
    .cfg_x_count(cfg_x_count), .cfg_x_step(cfg_x_step), .cfg_y_count(cfg_y_count),
    .cfg_y_step(cfg_y_step), .cfg_two_d(cfg_two_d), .cfg_circular(cfg_circular),
    .cfg_row_irq_en(cfg_row_irq_en), .elem_req(elem_req), .busy(busy),
    .addr_vld(addr_vld), .addr(addr), .row_done(row_done), .buf_done(buf_done)
  );

  int total = 0, failed = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_base, m_cur;
  logic [15:0] m_xs, m_ys;
  int          m_xn, m_yn, m_x, m_y;
  bit          m_busy = 0, m_circ = 0, m_rowirq = 0;

  function automatic logic [31:0] sx(input logic [15:0] s);
    return {{16{s[15]}}, s};
  endfunction

  function automatic int cnt_of(input logic [15:0] c);
    return (c == 16'd0) ? 65536 : int'(c);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_start(input logic [31:0] a, input logic [15:0] xc, input logic [15:0] xs,
                          input logic [15:0] yc, input logic [15:0] ys,
                          input bit td, input bit circ, input bit rie);
    cfg_start_addr = a; cfg_x_count = xc; cfg_x_step = xs; cfg_y_count = yc;
    cfg_y_step = ys; cfg_two_d = td; cfg_circular = circ; cfg_row_irq_en = rie;
    start = 1'b1; elem_req = 1'b0;
    m_base = a; m_cur = a; m_xs = xs; m_ys = ys;
    m_xn = cnt_of(xc); m_yn = td ? cnt_of(yc) : 1;
    m_x = m_xn; m_y = m_yn; m_busy = 1; m_circ = circ; m_rowirq = td && rie;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", {31'd0, busy}, 32'd1);
    chk("R2 no addr at start", {31'd0, addr_vld}, 32'd0);
  endtask

  task automatic cyc(input bit req, input string atag);
    bit          e_vld, e_row, e_buf;
    logic [31:0] e_addr;
    string       tag;
    elem_req = req;
    e_vld = req && m_busy;
    e_addr = m_cur; e_row = 0; e_buf = 0;
    tag = atag;
    if (e_vld) begin
      e_row = m_rowirq && (m_x == 1);
      e_buf = (m_x == 1) && (m_y == 1);
      if (m_x == 1) begin
        m_x = m_xn;
        if (m_y == 1) begin
          m_y = m_yn; m_cur = m_base;
          if (!m_circ) m_busy = 0;
        end else begin
          m_y--; m_cur = m_cur + sx(m_ys);
        end
      end else begin
        m_x--; m_cur = m_cur + sx(m_xs);
      end
    end
    @(negedge clk);
    chk({tag, " R2 addr_vld"}, {31'd0, addr_vld}, {31'd0, e_vld});
    if (e_vld) chk({tag, " address"}, addr, e_addr);
    chk({tag, " R10 row_done"}, {31'd0, row_done}, {31'd0, e_row});
    chk({tag, " R9 buf_done"}, {31'd0, buf_done}, {31'd0, e_buf});
    chk({tag, " R7/R8 busy"}, {31'd0, busy}, {31'd0, m_busy});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 addr_vld", {31'd0, addr_vld}, 32'd0);
    chk("R1 row_done", {31'd0, row_done}, 32'd0);
    chk("R1 buf_done", {31'd0, buf_done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", {31'd0, busy}, 32'd0);

    // R3 R7: 1-D stop, step +4, gapped requests
    do_start(32'h1000_0000, 16'd4, 16'd4, 16'd9, 16'd0, 0, 0, 1);
    for (int i = 0; i < 8; i++) cyc(i[0], "R3 linear");
    // R7 requests while idle ignored
    for (int i = 0; i < 4; i++) cyc(1, "R7 idle");

    // R4: de-interleave, inner +8, outer -20 (smaller than inner)
    do_start(32'h0000_2000, 16'd3, 16'd8, 16'd3, 16'hFFEC, 1, 0, 1);
    for (int i = 0; i < 12; i++) cyc(1, "R4 deinterleave");

    // R6: 1-D with outer count ignored
    do_start(32'h0000_0100, 16'd3, 16'hFFFE, 16'd5, 16'd100, 0, 0, 1);
    for (int i = 0; i < 5; i++) cyc(1, "R6 one row");

    // R8 R9 R10: circular 2-D with row pulses
    do_start(32'h8000_0000, 16'd2, 16'd2, 16'd3, 16'd16, 1, 1, 1);
    for (int i = 0; i < 20; i++) cyc(1, "R8 circular");
    // R2 restart while busy
    do_start(32'h0000_4000, 16'd2, 16'd1, 16'd2, 16'd1, 1, 0, 0);
    for (int i = 0; i < 6; i++) cyc(1, "R2 restart");

    // R5: count 0 means 65536
    do_start(32'h0000_0000, 16'd0, 16'd1, 16'd0, 16'd0, 0, 0, 0);
    for (int i = 0; i < 65538; i++) cyc(1, "R5 full count");

    // random configurations
    for (int k = 0; k < 40; k++) begin
      do_start($urandom, 16'($urandom_range(1, 5)), 16'($urandom),
               16'($urandom_range(1, 4)), 16'($urandom),
               bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
               bit'($urandom_range(0, 1)));
      for (int i = 0; i < 60; i++) cyc($urandom_range(0, 3) != 0, "R3/R4 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule